// File: doc/BRIEF.md
# Cascadable Synchronous Line Buffer

A single-clock, two-port byte memory for streams processed one line at a time. It has one write port and one read port, which share an array and may both act on the same clock edge. Neither port has address pins. Each port walks the array with its own internal counter, steered by an enable strobe and a reload strobe. Each counter can count up or down. A reload either loads a preset value or clears the counter. When a read and a write meet at one location in the same cycle, the read returns the byte stored before that edge. Because of this, the data output of one buffer can feed the data input of the next to form a longer delay line.

The low counter bits address the array. The upper counter bits form a bank number, which is compared with a static expansion ID. A port whose bank differs from the ID is inactive: a write stores nothing, and the read output is not driven. Its counter still moves while its enable is high, so several buffers on a shared bus can split one long address space between them. The output enable is active low and works in either of two modes: it acts at once (asynchronous), or it is sampled on the clock edge (synchronous). High impedance is modelled as a data bus `dout` plus a drive qualifier `dout_oe`. With the default parameters the array holds 1024 bytes and each counter is 13 bits wide. Setting `ADDR_W=13` and `CNT_W=16` gives the 8192-byte arrangement.

Top module: `lnbuf_top`

## Requirements
- R1: In the first cycle after the synchronous reset is released, `dout` is 0x00, both counters are 0, and both roll-over flags are 0. With `oe_n` low, an expansion ID of 0 and asynchronous mode, `dout_oe` is 1.
- R2: On an edge where `wr_en` is 1 and the write bank matches, `din` is stored at the low `ADDR_W` bits of the write counter, and the write counter then moves one step.
- R3: On an edge where `rd_en` is 1 and the read bank matches, the byte at the read counter's low bits is loaded into `dout`, where it is visible after that edge. The read counter then moves one step.
- R4: When a matching read and a matching write hit the same location on one edge, `dout` receives the byte stored before that edge, and the new byte is stored for later reads.
- R5: A reload strobe takes precedence over counting. With the preset-select bit at 1, the counter loads its preset input. With the bit at 0, it loads 0 when counting up and all ones when counting down.
- R6: A direction bit of 0 counts up and 1 counts down, wrapping modulo 2^`CNT_W`. A counter holds its value when its enable and reload are both low.
- R7: When the write bank (counter bits above `ADDR_W`) differs from `cfg_exp_id`, a write-enabled edge stores nothing, but the write counter still moves.
- R8: While the read bank differs from `cfg_exp_id`, `dout_oe` is 0 whatever `oe_n` is, and the read counter still moves on read-enabled edges.
- R9: With `cfg_oe_sync`=0, `dout_oe` follows `oe_n` (active low) without waiting for a clock edge.
- R10: With `cfg_oe_sync`=1, `oe_n` is sampled on the rising edge, and `dout_oe` changes only after that edge.
- R11: A counter's roll-over flag rises after a down-count step from 0 to all ones. It stays high until its clear input is sampled low, and the flag is 0 after that edge. An up-count wrap never sets the flag.
- R12: `dout` keeps its value on edges without a matching read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous reset, active high |
| cfg_exp_id | input | CNT_W-ADDR_W | Expansion ID compared with each counter's bank bits |
| cfg_wr_preset_sel | input | 1 | Write reload source: 1 = preset, 0 = clear |
| cfg_wr_down | input | 1 | Write counter direction: 1 = down |
| cfg_rd_preset_sel | input | 1 | Read reload source: 1 = preset, 0 = clear |
| cfg_rd_down | input | 1 | Read counter direction: 1 = down |
| cfg_oe_sync | input | 1 | 1 = output enable sampled on the clock edge |
| wr_preset | input | CNT_W | Write counter preset value |
| rd_preset | input | CNT_W | Read counter preset value |
| wr_en | input | 1 | Write strobe |
| wr_reload | input | 1 | Write counter reload strobe |
| wr_flag_clr_n | input | 1 | Write roll-over flag clear, active low |
| din | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_reload | input | 1 | Read counter reload strobe |
| rd_flag_clr_n | input | 1 | Read roll-over flag clear, active low |
| oe_n | input | 1 | Output enable, active low |
| dout | output | DATA_W | Read data register |
| dout_oe | output | 1 | 1 = `dout` is driven |
| wr_flag | output | 1 | Write counter roll-over flag |
| rd_flag | output | 1 | Read counter roll-over flag |

## Verification
A read and a write can land on the same array location on one edge. The bench forces this by reloading both counters to zero together and then strobing both enables in the following cycle. The scoreboard expects the byte that was at that location before the edge. A later reread of the location, after a read reload, must return the newly written byte. Bank mismatch is covered on the same edge-by-edge basis. A suppressed write is aimed at a location that holds a known earlier value, and that value must still be there when it is read back. A run of unmatched reads must leave the read counter exactly where the counted steps put it.

// File: rtl/lnbuf_pkg.sv
package lnbuf_pkg;

    localparam int LB_DATA_W   = 8;
    localparam int LB_ADDR_W   = 10;
    localparam int LB_CNT_W    = 13;
    localparam int LB_NUM_PORT = 2;
    localparam int LB_PORT_WR  = 0;
    localparam int LB_PORT_RD  = 1;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;

    typedef enum logic {
        RLD_CLEAR  = 1'b0,
        RLD_PRESET = 1'b1
    } rld_src_e;

    typedef struct packed {
        rld_src_e src;
        cnt_dir_e dir;
    } ctr_cfg_t;

    function automatic ctr_cfg_t make_ctr_cfg(input logic preset_sel, input logic down);
        ctr_cfg_t c;
        c.src = preset_sel ? RLD_PRESET : RLD_CLEAR;
        c.dir = down ? DIR_DOWN : DIR_UP;
        return c;
    endfunction

endpackage

// File: rtl/lnbuf_ctr.sv
module lnbuf_ctr
    import lnbuf_pkg::*;
#(
    parameter int CNT_W = LB_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  ctr_cfg_t         cfg,
    input  logic [CNT_W-1:0] preset,
    input  logic             en,
    input  logic             reload,
    input  logic             flag_clr_n,
    output logic [CNT_W-1:0] cnt,
    output logic             flag
);

    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONES = '1;

    logic [CNT_W-1:0] step_val;
    logic [CNT_W-1:0] clear_val;
    logic             wrap_down;

    always_comb begin
        step_val  = (cfg.dir == DIR_DOWN) ? cnt - 1'b1 : cnt + 1'b1;
        clear_val = (cfg.dir == DIR_DOWN) ? ONES : ZERO;
        wrap_down = en && !reload && (cfg.dir == DIR_DOWN) && (cnt == ZERO);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= ZERO;
        end else if (reload) begin
            cnt <= (cfg.src == RLD_PRESET) ? preset : clear_val;
        end else if (en) begin
            cnt <= step_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (!flag_clr_n) begin
            flag <= 1'b0;
        end else if (wrap_down) begin
            flag <= 1'b1;
        end
    end

    assert_up_step_R6: assert property (@(posedge clk) disable iff (rst)
        (en && !reload && cfg.dir == DIR_UP) |=> cnt == CNT_W'($past(cnt) + 1'b1));

    assert_down_step_R6: assert property (@(posedge clk) disable iff (rst)
        (en && !reload && cfg.dir == DIR_DOWN) |=> cnt == CNT_W'($past(cnt) - 1'b1));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!en && !reload) |=> $stable(cnt));

    assert_flag_clear_R11: assert property (@(posedge clk) disable iff (rst)
        !flag_clr_n |=> !flag);

endmodule

// File: rtl/lnbuf_mem.sv
module lnbuf_mem
    import lnbuf_pkg::*;
#(
    parameter int DATA_W = LB_DATA_W,
    parameter int ADDR_W = LB_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_fire,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_fire,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] dout
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // Both processes sample the array before this edge's update lands,
    // so a colliding read sees the previous byte.
    always_ff @(posedge clk) begin
        if (wr_fire) begin
            store[waddr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (rd_fire) begin
            dout <= store[raddr];
        end
    end

    assert_dout_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !rd_fire |=> $stable(dout));

endmodule

// File: rtl/lnbuf_oe.sv
module lnbuf_oe (
    input  logic clk,
    input  logic rst,
    input  logic sync_mode,
    input  logic oe_n,
    input  logic rd_match,
    output logic drive
);

    logic oe_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_n_q <= 1'b1;
        end else begin
            oe_n_q <= oe_n;
        end
    end

    always_comb begin
        drive = rd_match && !(sync_mode ? oe_n_q : oe_n);
    end

    assert_sync_oe_R10: assert property (@(posedge clk) disable iff (rst)
        (sync_mode && $past(sync_mode) && $past(oe_n)) |-> !drive);

endmodule

// File: rtl/lnbuf_top.sv
module lnbuf_top
    import lnbuf_pkg::*;
#(
    parameter int DATA_W = LB_DATA_W,
    parameter int ADDR_W = LB_ADDR_W,
    parameter int CNT_W  = LB_CNT_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CNT_W-ADDR_W-1:0] cfg_exp_id,
    input  logic                    cfg_wr_preset_sel,
    input  logic                    cfg_wr_down,
    input  logic                    cfg_rd_preset_sel,
    input  logic                    cfg_rd_down,
    input  logic                    cfg_oe_sync,
    input  logic [CNT_W-1:0]        wr_preset,
    input  logic [CNT_W-1:0]        rd_preset,
    input  logic                    wr_en,
    input  logic                    wr_reload,
    input  logic                    wr_flag_clr_n,
    input  logic [DATA_W-1:0]       din,
    input  logic                    rd_en,
    input  logic                    rd_reload,
    input  logic                    rd_flag_clr_n,
    input  logic                    oe_n,
    output logic [DATA_W-1:0]       dout,
    output logic                    dout_oe,
    output logic                    wr_flag,
    output logic                    rd_flag
);

    localparam int EXP_W = CNT_W - ADDR_W;

    ctr_cfg_t                 port_cfg    [LB_NUM_PORT];
    logic [CNT_W-1:0]         port_preset [LB_NUM_PORT];
    logic [CNT_W-1:0]         port_cnt    [LB_NUM_PORT];
    logic [LB_NUM_PORT-1:0]   port_en;
    logic [LB_NUM_PORT-1:0]   port_reload;
    logic [LB_NUM_PORT-1:0]   port_clr_n;
    logic [LB_NUM_PORT-1:0]   port_flag;
    logic [LB_NUM_PORT-1:0]   port_match;

    assign port_cfg[LB_PORT_WR]    = make_ctr_cfg(cfg_wr_preset_sel, cfg_wr_down);
    assign port_cfg[LB_PORT_RD]    = make_ctr_cfg(cfg_rd_preset_sel, cfg_rd_down);
    assign port_preset[LB_PORT_WR] = wr_preset;
    assign port_preset[LB_PORT_RD] = rd_preset;
    assign port_en                 = {rd_en, wr_en};
    assign port_reload             = {rd_reload, wr_reload};
    assign port_clr_n              = {rd_flag_clr_n, wr_flag_clr_n};

    for (genvar p = 0; p < LB_NUM_PORT; p++) begin : g_port
        lnbuf_ctr #(
            .CNT_W (CNT_W)
        ) u_ctr (
            .clk        (clk),
            .rst        (rst),
            .cfg        (port_cfg[p]),
            .preset     (port_preset[p]),
            .en         (port_en[p]),
            .reload     (port_reload[p]),
            .flag_clr_n (port_clr_n[p]),
            .cnt        (port_cnt[p]),
            .flag       (port_flag[p])
        );

        assign port_match[p] = (port_cnt[p][CNT_W-1 -: EXP_W] == cfg_exp_id);
    end

    logic wr_fire;
    logic rd_fire;

    assign wr_fire = wr_en && port_match[LB_PORT_WR];
    assign rd_fire = rd_en && port_match[LB_PORT_RD];

    lnbuf_mem #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_fire (wr_fire),
        .waddr   (port_cnt[LB_PORT_WR][ADDR_W-1:0]),
        .din     (din),
        .rd_fire (rd_fire),
        .raddr   (port_cnt[LB_PORT_RD][ADDR_W-1:0]),
        .dout    (dout)
    );

    lnbuf_oe u_oe (
        .clk       (clk),
        .rst       (rst),
        .sync_mode (cfg_oe_sync),
        .oe_n      (oe_n),
        .rd_match  (port_match[LB_PORT_RD]),
        .drive     (dout_oe)
    );

    assign wr_flag = port_flag[LB_PORT_WR];
    assign rd_flag = port_flag[LB_PORT_RD];

    assert_bank_nodrive_R8: assert property (@(posedge clk) disable iff (rst)
        (port_cnt[LB_PORT_RD][CNT_W-1 -: EXP_W] != cfg_exp_id) |-> !dout_oe);

    assert_wr_bank_moves_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_reload && !port_match[LB_PORT_WR]) |=> !$stable(port_cnt[LB_PORT_WR]));

endmodule

// File: tb/lnbuf_top_tb.sv
module lnbuf_top_tb;

    localparam int  DW  = 8;
    localparam int  AW  = 10;
    localparam int  CW  = 13;
    localparam int  EW  = CW - AW;
    localparam time CLK = 8ns;
    localparam logic [CW-1:0] ALL1 = '1;
    localparam logic [CW-1:0] TOPA = CW'((1 << AW) - 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [EW-1:0] cfg_exp_id = '0;
    logic          cfg_wr_preset_sel = 1'b0, cfg_wr_down = 1'b0;
    logic          cfg_rd_preset_sel = 1'b0, cfg_rd_down = 1'b0;
    logic          cfg_oe_sync = 1'b0;
    logic [CW-1:0] wr_preset = '0, rd_preset = '0;
    logic          wr_en = 1'b0, wr_reload = 1'b0, wr_flag_clr_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic          rd_en = 1'b0, rd_reload = 1'b0, rd_flag_clr_n = 1'b1;
    logic          oe_n = 1'b0;
    logic [DW-1:0] dout;
    logic          dout_oe, wr_flag, rd_flag;

    logic          sb_arm = 1'b0;

    typedef struct {
        logic [DW-1:0] data;
        string         tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int checks = 0;
    int failures = 0;

    always #(CLK/2) clk = ~clk;

    lnbuf_top #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .cfg_exp_id(cfg_exp_id),
        .cfg_wr_preset_sel(cfg_wr_preset_sel), .cfg_wr_down(cfg_wr_down),
        .cfg_rd_preset_sel(cfg_rd_preset_sel), .cfg_rd_down(cfg_rd_down),
        .cfg_oe_sync(cfg_oe_sync), .wr_preset(wr_preset), .rd_preset(rd_preset),
        .wr_en(wr_en), .wr_reload(wr_reload), .wr_flag_clr_n(wr_flag_clr_n),
        .din(din), .rd_en(rd_en), .rd_reload(rd_reload),
        .rd_flag_clr_n(rd_flag_clr_n), .oe_n(oe_n), .dout(dout),
        .dout_oe(dout_oe), .wr_flag(wr_flag), .rd_flag(rd_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [DW-1:0] v);
        wr_en = 1'b1; din = v;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic do_read(input bit expect_data, input logic [DW-1:0] v, input string tag);
        sb_item_t it;
        rd_en = 1'b1; sb_arm = expect_data;
        if (expect_data) begin
            it.data = v; it.tag = tag;
            sb_q.push_back(it);
        end
        cyc();
        rd_en = 1'b0; sb_arm = 1'b0;
    endtask

    task automatic rd_load(input logic sel, input logic down, input logic [CW-1:0] val);
        cfg_rd_preset_sel = sel; cfg_rd_down = down; rd_preset = val; rd_reload = 1'b1;
        cyc();
        rd_reload = 1'b0;
    endtask

    task automatic wr_load(input logic sel, input logic down, input logic [CW-1:0] val);
        cfg_wr_preset_sel = sel; cfg_wr_down = down; wr_preset = val; wr_reload = 1'b1;
        cyc();
        wr_reload = 1'b0;
    endtask

    // scoreboard monitor: a read strobed at an edge is judged at the next falling edge
    initial begin
        bit fire;
        sb_item_t it;
        forever begin
            @(posedge clk);
            fire = rd_en && sb_arm;
            @(negedge clk);
            if (fire) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R3 scoreboard empty", 0, 1);
                end else begin
                    it = sb_q.pop_front();
                    chk(dout === it.data, it.tag, int'(dout), int'(it.data));
                end
            end
        end
    end

    initial begin
        #(CLK * 200000);
        chk(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc();
        rst = 1'b0;
        cyc();
        // R1 reset state
        chk(dout == 8'h00, "R1 dout", int'(dout), 0);
        chk(!rd_flag && !wr_flag, "R1 flags", int'({wr_flag, rd_flag}), 0);
        chk(dout_oe == 1'b1, "R1 drive", int'(dout_oe), 1);

        // R2 / R3 basic stream
        for (int i = 0; i < 4; i++) do_write(DW'(8'hA0 + i));
        for (int i = 0; i < 4; i++) do_read(1'b1, DW'(8'hA0 + i), "R3 stream");

        // R12 hold without read
        cyc();
        chk(dout == 8'hA3, "R12 hold", int'(dout), 8'hA3);

        // R4 same location same edge
        wr_reload = 1'b1; rd_reload = 1'b1;
        cyc();
        wr_reload = 1'b0; rd_reload = 1'b0;
        wr_en = 1'b1; din = 8'h55;
        do_read(1'b1, 8'hA0, "R4 old byte");
        wr_en = 1'b0;
        rd_load(1'b0, 1'b0, '0);
        do_read(1'b1, 8'h55, "R4 new byte");

        // R5 preset reload
        rd_load(1'b1, 1'b0, CW'(2));
        do_read(1'b1, 8'hA2, "R5 preset");
        do_read(1'b1, 8'hA3, "R2 advance");

        // R6 down count, R11 roll-over flag
        rd_load(1'b1, 1'b1, CW'(3));
        do_read(1'b1, 8'hA3, "R6 down");
        do_read(1'b1, 8'hA2, "R6 down");
        do_read(1'b1, 8'hA1, "R6 down");
        chk(rd_flag == 1'b0, "R11 no early flag", int'(rd_flag), 0);
        do_read(1'b1, 8'h55, "R6 down to zero");
        chk(rd_flag == 1'b1, "R11 flag set", int'(rd_flag), 1);
        chk(dout_oe == 1'b0, "R8 bank mismatch", int'(dout_oe), 0);
        do_read(1'b0, '0, "");
        chk(rd_flag == 1'b1, "R11 flag held", int'(rd_flag), 1);
        chk(dout_oe == 1'b0, "R8 still off", int'(dout_oe), 0);
        rd_flag_clr_n = 1'b0;
        cyc();
        rd_flag_clr_n = 1'b1;
        chk(rd_flag == 1'b0, "R11 flag cleared", int'(rd_flag), 0);

        // R5 clear-down gives all ones; R8 counter moves while unmatched; R6 up wrap
        rd_load(1'b0, 1'b1, '0);
        chk(dout_oe == 1'b0, "R5 clear down all ones", int'(dout_oe), 0);
        cfg_rd_down = 1'b0;
        do_read(1'b0, '0, "");
        chk(dout_oe == 1'b1, "R8 counter advanced", int'(dout_oe), 1);
        chk(rd_flag == 1'b0, "R11 up wrap no flag", int'(rd_flag), 0);
        do_read(1'b1, 8'h55, "R6 up wrap to zero");

        // R7 write bank mismatch
        wr_load(1'b1, 1'b0, TOPA);
        do_write(8'h11);
        wr_load(1'b1, 1'b0, ALL1);
        do_write(8'hEE);
        do_write(8'h77);
        rd_load(1'b1, 1'b0, TOPA);
        do_read(1'b1, 8'h11, "R7 suppressed write");
        rd_load(1'b1, 1'b0, '0);
        do_read(1'b1, 8'h77, "R7 counter moved");

        // R11 write flag
        wr_load(1'b1, 1'b1, '0);
        do_write(8'h77);
        chk(wr_flag == 1'b1, "R11 write flag", int'(wr_flag), 1);
        wr_flag_clr_n = 1'b0;
        cyc();
        wr_flag_clr_n = 1'b1;
        chk(wr_flag == 1'b0, "R11 write flag clear", int'(wr_flag), 0);

        // R9 asynchronous enable
        oe_n = 1'b1;
        #1;
        chk(dout_oe == 1'b0, "R9 async off", int'(dout_oe), 0);
        oe_n = 1'b0;
        #1;
        chk(dout_oe == 1'b1, "R9 async on", int'(dout_oe), 1);

        // R10 synchronous enable
        @(negedge clk);
        cfg_oe_sync = 1'b1;
        oe_n = 1'b1;
        #1;
        chk(dout_oe == 1'b1, "R10 waits for edge", int'(dout_oe), 1);
        cyc();
        chk(dout_oe == 1'b0, "R10 off after edge", int'(dout_oe), 0);
        oe_n = 1'b0;
        #1;
        chk(dout_oe == 1'b0, "R10 waits for edge", int'(dout_oe), 0);
        cyc();
        chk(dout_oe == 1'b1, "R10 on after edge", int'(dout_oe), 1);

        cyc();
        chk(sb_q.size() == 0, "R3 scoreboard drained", sb_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule